// File: doc/BRIEF.md
# Paced serial command transmitter

This block sends single-letter commands to a slow time receiver over an asynchronous serial line. The receiver draws power for its transmitter from the host's line and echoes every character it receives. The link therefore cannot carry characters back to back. The host raises a one-cycle strobe with a letter. The block frames and sends that letter, then a carriage return. After each character it waits for the matching echo and then for a settle delay before it sends the next character.

Each command is identified by the low nibble of its letter. After the echo of the carriage return, a command that expects an answer holds a response-window flag for a fixed time, so that a later decoder knows when the receiver's reply may arrive. The resync command expects no answer, so it finishes after the final settle delay. A wrong echo or a missing echo aborts the command and raises a one-cycle error pulse. The block stays busy until the command ends.

Top module: `pacedCmdTx`

## Requirements
- R1: While reset is asserted and directly after it, txLine is high (mark) and busy, respWindow, donePulse and errPulse are all low.
- R2: Every transmitted character is one low start bit, then 8 data bits LSB first, with no parity bit, then two high stop bits. Each bit lasts CLK_HZ/BAUD clock cycles.
- R3: cmdValid in idle with a letter whose low nibble is 0x7, 0x8 or 0xF starts a command. The full letter byte is sent, followed by 0x0D. busy is high from the cycle after the strobe.
- R4: A character is started only after the echo of the previous character of the same command has been received and at least GUARD_MS has elapsed since then.
- R5: For low nibble 0x7 or 0xF, respWindow goes high right after the echo of 0x0D is received and stays high for exactly RESP_MS worth of cycles (at least 1 s). donePulse then pulses for one cycle and busy falls in that same cycle.
- R6: For low nibble 0x8, respWindow never rises. donePulse pulses once after the 0x0D echo plus the guard delay.
- R7: cmdValid in idle with any other low nibble is ignored: busy stays low and nothing is transmitted.
- R8: cmdValid while busy is ignored. The command in progress sends no extra character and completes as it would have without the strobe.
- R9: An echo whose byte differs from the byte sent, or whose stop bit is low, aborts the command. errPulse is high for one cycle, busy falls, and no further character of that command is sent.
- R10: If no echo arrives within ECHO_TIMEOUT_MS of the start of a character, errPulse is raised, exactly that many cycles after the start bit began (within 2 cycles), and busy falls.
- R11: donePulse and errPulse are never high together. busy falls only in a cycle where one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdLetter | input | 8 | Command letter, sampled with cmdValid |
| rxLine | input | 1 | Serial line from the receiver (echoes and replies) |
| txLine | output | 1 | Serial line to the receiver |
| busy | output | 1 | A command is in progress |
| respWindow | output | 1 | Window in which the receiver's reply may arrive |
| donePulse | output | 1 | One-cycle pulse on successful completion |
| errPulse | output | 1 | One-cycle pulse on echo mismatch or echo timeout |

## Verification
The assertions assume that rxLine idles high and that the echo, when it comes, is a complete frame at the same bit rate. They also assume that no unrelated traffic appears on rxLine while a character waits for its echo. The bench meets these assumptions with an echo model that retransmits only what it has just decoded from txLine. The model starts once the first stop bit has been seen. Its corrupt mode flips the low data bit and its drop mode stays silent. Command strobes are single cycles driven between clock edges. The overlapping strobe is placed well inside a running command.

// File: rtl/pace_pkg.sv
`timescale 1ns/1ps
package pace_pkg;

  localparam int DATA_BITS = 8;
  localparam logic [7:0] CR_BYTE = 8'h0D;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_ECHO,
    ST_GUARD,
    ST_RESP
  } paceState_t;

  typedef enum logic [1:0] {
    CK_NONE,
    CK_QUALITY,
    CK_RESYNC,
    CK_STAMP
  } cmdKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCmd;
    logic loadChar;
    logic selCr;
    logic armEcho;
    logic armGuard;
    logic armResp;
  } paceStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic txIdle;
    logic echoSeen;
    logic echoGood;
    logic timerDone;
  } paceStatus_t;

  // only the low nibble of a letter selects the command
  function automatic cmdKind_t decodeKind(input logic [3:0] nib);
    cmdKind_t k;
    case (nib)
      4'h7:    k = CK_QUALITY;
      4'h8:    k = CK_RESYNC;
      4'hF:    k = CK_STAMP;
      default: k = CK_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/paceDatapath.sv
`timescale 1ns/1ps
module paceDatapath
  import pace_pkg::*;
#(
  parameter int BIT_CYC   = 20,
  parameter int STOP_BITS = 2,
  parameter int GUARD_CYC = 60,
  parameter int ECHO_CYC  = 600,
  parameter int RESP_CYC  = 6000
) (
  input  logic        clk,
  input  logic        rstN,
  input  paceStrobe_t strb,
  input  logic [7:0]  cmdLetter,
  input  logic        rxLine,
  output logic        txLine,
  output paceStatus_t stat
);

  localparam int FRAME = 1 + DATA_BITS + STOP_BITS;
  localparam int BW    = $clog2(BIT_CYC + 1);
  localparam int FW    = $clog2(FRAME + 1);
  localparam int MAX_A = (ECHO_CYC > GUARD_CYC) ? ECHO_CYC : GUARD_CYC;
  localparam int MAX_T = (MAX_A > RESP_CYC) ? MAX_A : RESP_CYC;
  localparam int TW    = $clog2(MAX_T + 1);
  localparam logic [BW-1:0] FULL_LOAD = BW'(BIT_CYC - 1);
  localparam logic [BW-1:0] HALF_LOAD = BW'(BIT_CYC / 2 - 1);

  // ---------------- command letter and byte under way ----------------
  logic [7:0] letterReg;
  logic [7:0] sentByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      letterReg <= '0;
      sentByte  <= '0;
    end else begin
      if (strb.latchCmd) letterReg <= cmdLetter;
      if (strb.loadChar) sentByte  <= strb.selCr ? CR_BYTE : letterReg;
    end
  end

  // ---------------- transmitter ----------------
  logic             txActive;
  logic [FRAME-1:0] txShift;
  logic [FW-1:0]    txBitsLeft;
  logic [BW-1:0]    txBaud;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive   <= 1'b0;
      txShift    <= '1;
      txBitsLeft <= '0;
      txBaud     <= '0;
    end else if (strb.loadChar) begin
      txActive   <= 1'b1;
      txShift    <= {{STOP_BITS{1'b1}}, (strb.selCr ? CR_BYTE : letterReg), 1'b0};
      txBitsLeft <= FW'(FRAME);
      txBaud     <= FULL_LOAD;
    end else if (txActive) begin
      if (txBaud != '0) begin
        txBaud <= txBaud - 1'b1;
      end else begin
        txBaud     <= FULL_LOAD;
        txShift    <= {1'b1, txShift[FRAME-1:1]};
        txBitsLeft <= txBitsLeft - 1'b1;
        if (txBitsLeft == FW'(1)) txActive <= 1'b0;
      end
    end
  end

  assign txLine      = txActive ? txShift[0] : 1'b1;
  assign stat.txIdle = !txActive;

  // ---------------- echo receiver ----------------
  logic       rxMeta, rxSync;
  logic       rxBusy;
  logic [BW-1:0] rxBaud;
  logic [3:0] rxIdx;
  logic [7:0] rxShift;
  logic       rxDone;
  logic       rxStopOk;
  logic [7:0] rxByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta   <= 1'b1;
      rxSync   <= 1'b1;
      rxBusy   <= 1'b0;
      rxBaud   <= '0;
      rxIdx    <= '0;
      rxShift  <= '0;
      rxDone   <= 1'b0;
      rxStopOk <= 1'b0;
      rxByte   <= '0;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
      rxDone <= 1'b0;
      if (!rxBusy) begin
        if (!rxSync) begin
          rxBusy <= 1'b1;
          rxBaud <= HALF_LOAD;
          rxIdx  <= '0;
        end
      end else if (rxBaud != '0) begin
        rxBaud <= rxBaud - 1'b1;
      end else begin
        rxBaud <= FULL_LOAD;
        rxIdx  <= rxIdx + 1'b1;
        if (rxIdx == 4'd0) begin
          if (rxSync) rxBusy <= 1'b0;   // glitch, not a start bit
        end else if (rxIdx <= 4'(DATA_BITS)) begin
          rxShift <= {rxSync, rxShift[7:1]};
        end else begin
          rxBusy   <= 1'b0;
          rxDone   <= 1'b1;
          rxStopOk <= rxSync;
          rxByte   <= rxShift;
        end
      end
    end
  end

  assign stat.echoSeen = rxDone;
  assign stat.echoGood = rxDone && rxStopOk && (rxByte == sentByte);

  // ---------------- shared countdown timer ----------------
  logic [TW-1:0] timerCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (strb.armEcho) begin
      timerCnt <= TW'(ECHO_CYC - 1);
    end else if (strb.armGuard) begin
      timerCnt <= TW'(GUARD_CYC - 1);
    end else if (strb.armResp) begin
      timerCnt <= TW'(RESP_CYC - 1);
    end else if (timerCnt != '0) begin
      timerCnt <= timerCnt - 1'b1;
    end
  end

  assign stat.timerDone = (timerCnt == '0);

  // ---------------- assertions ----------------
  // a new character never cuts into a frame still on the line (R4)
  p_load_when_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadChar |-> !txActive);

  // the last STOP_BITS bit times of a frame are mark (R2)
  p_stop_mark_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && txBitsLeft <= FW'(STOP_BITS)) |-> txLine);

  // a new frame begins with a start bit (R2)
  p_start_space_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadChar |=> !txLine);

  // an expired timer stays expired until re-armed (R10)
  p_timer_rest_r10: assert property (@(posedge clk) disable iff (!rstN)
    (timerCnt == '0 && !strb.armEcho && !strb.armGuard && !strb.armResp) |=> (timerCnt == '0));

endmodule

// File: rtl/paceControl.sv
`timescale 1ns/1ps
module paceControl
  import pace_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdLetter,
  input  paceStatus_t stat,
  output paceStrobe_t strb,
  output logic        busy,
  output logic        respWindow,
  output logic        donePulse,
  output logic        errPulse
);

  paceState_t state, stateNext;
  cmdKind_t   kind, kindNext, reqKind;
  logic       onCr, onCrNext;
  logic       doneNext, errNext;

  assign reqKind = decodeKind(cmdLetter[3:0]);

  always_comb begin
    stateNext = state;
    kindNext  = kind;
    onCrNext  = onCr;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (cmdValid && reqKind != CK_NONE) begin
          strb.latchCmd = 1'b1;
          kindNext      = reqKind;
          onCrNext      = 1'b0;
          stateNext     = ST_SEND;
        end
      end
      ST_SEND: begin
        if (stat.txIdle) begin
          strb.loadChar = 1'b1;
          strb.selCr    = onCr;
          strb.armEcho  = 1'b1;
          stateNext     = ST_ECHO;
        end
      end
      ST_ECHO: begin
        if (stat.echoSeen) begin
          if (!stat.echoGood) begin
            errNext   = 1'b1;
            stateNext = ST_IDLE;
          end else if (onCr && kind != CK_RESYNC) begin
            strb.armResp = 1'b1;
            stateNext    = ST_RESP;
          end else begin
            strb.armGuard = 1'b1;
            stateNext     = ST_GUARD;
          end
        end else if (stat.timerDone) begin
          errNext   = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_GUARD: begin
        if (stat.timerDone) begin
          if (onCr) begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            onCrNext  = 1'b1;
            stateNext = ST_SEND;
          end
        end
      end
      ST_RESP: begin
        if (stat.timerDone) begin
          doneNext  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= CK_NONE;
      onCr      <= 1'b0;
      donePulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      state     <= stateNext;
      kind      <= kindNext;
      onCr      <= onCrNext;
      donePulse <= doneNext;
      errPulse  <= errNext;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign respWindow = (state == ST_RESP);

  // ---------------- assertions ----------------
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && errPulse));

  p_busy_fall_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (donePulse || errPulse));

  p_window_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    respWindow |-> busy);

  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> $stable(kind));

  p_no_window_resync_r6: assert property (@(posedge clk) disable iff (!rstN)
    (kind == CK_RESYNC) |-> !respWindow);

endmodule

// File: rtl/pacedCmdTx.sv
`timescale 1ns/1ps
module pacedCmdTx
  import pace_pkg::*;
#(
  parameter int CLK_HZ          = 125_000_000,
  parameter int BAUD            = 300,
  parameter int STOP_BITS       = 2,
  parameter int GUARD_MS        = 10,
  parameter int ECHO_TIMEOUT_MS = 100,
  parameter int RESP_MS         = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdLetter,
  input  logic       rxLine,
  output logic       txLine,
  output logic       busy,
  output logic       respWindow,
  output logic       donePulse,
  output logic       errPulse
);

  localparam longint CLK_L     = longint'(CLK_HZ);
  localparam int     BIT_CYC   = CLK_HZ / BAUD;
  localparam int     GUARD_CYC = int'((CLK_L * GUARD_MS) / 1000);
  localparam int     ECHO_CYC  = int'((CLK_L * ECHO_TIMEOUT_MS) / 1000);
  localparam int     RESP_CYC  = int'((CLK_L * RESP_MS) / 1000);

  paceStrobe_t strb;
  paceStatus_t stat;

  paceControl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdLetter  (cmdLetter),
    .stat       (stat),
    .strb       (strb),
    .busy       (busy),
    .respWindow (respWindow),
    .donePulse  (donePulse),
    .errPulse   (errPulse)
  );

  paceDatapath #(
    .BIT_CYC   (BIT_CYC),
    .STOP_BITS (STOP_BITS),
    .GUARD_CYC (GUARD_CYC),
    .ECHO_CYC  (ECHO_CYC),
    .RESP_CYC  (RESP_CYC)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdLetter (cmdLetter),
    .rxLine    (rxLine),
    .txLine    (txLine),
    .stat      (stat)
  );

endmodule

// File: tb/test_pacedCmdTx.sv
`timescale 1ns/1ps
module test_pacedCmdTx;

  localparam int CLK_HZ    = 6000;
  localparam int BAUD      = 300;
  localparam int BIT_CYC   = CLK_HZ / BAUD;
  localparam int GUARD_CYC = CLK_HZ * 10 / 1000;
  localparam int ECHO_CYC  = CLK_HZ * 100 / 1000;
  localparam int RESP_CYC  = CLK_HZ * 1000 / 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdLetter = 8'h00;
  logic rxLine;
  logic txLine, busy, respWindow, donePulse, errPulse;

  int nTests = 0;
  int nFail = 0;
  int cyc = 0;
  int txStarts = 0;
  int respCnt = 0;
  int doneCnt = 0;
  int errCnt = 0;
  int errCyc = 0;
  int lastStart = 0;
  int echoStopCyc = -1;
  int echoMode = 0;          // 0 faithful, 1 corrupt, 2 silent
  logic echoPending = 1'b0;
  logic [7:0] echoByte = 8'h00;
  logic [7:0] expQ[$];
  bit finished = 1'b0;

  always #4 clk = ~clk;      // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pacedCmdTx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_pacedCmdTx (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdLetter(cmdLetter),
    .rxLine(rxLine), .txLine(txLine), .busy(busy), .respWindow(respWindow),
    .donePulse(donePulse), .errPulse(errPulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  // event counters
  initial begin : evMon
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (respWindow) respCnt++;
        if (donePulse) doneCnt++;
        if (errPulse) begin errCnt++; errCyc = cyc; end
      end
    end
  end

  // monitor: decodes txLine, pops the scoreboard, requests the echo
  logic [7:0] mByte, mExp;
  logic mStart, mStop1, mStop2;
  initial begin : txMon
    forever begin
      @(negedge clk);
      if (rstN && !txLine) begin
        lastStart = cyc;
        txStarts++;
        if (echoStopCyc >= 0)
          check(lastStart - echoStopCyc >= GUARD_CYC, "R4 guard after echo",
                lastStart - echoStopCyc, GUARD_CYC);
        repeat (BIT_CYC / 2) @(negedge clk);
        mStart = txLine;
        for (int i = 0; i < 8; i++) begin
          repeat (BIT_CYC) @(negedge clk);
          mByte[i] = txLine;
        end
        repeat (BIT_CYC) @(negedge clk);
        mStop1 = txLine;
        if (echoMode != 2) begin
          echoByte = (echoMode == 1) ? (mByte ^ 8'h01) : mByte;
          echoPending = 1'b1;
        end
        repeat (BIT_CYC) @(negedge clk);
        mStop2 = txLine;
        check(!mStart && mStop1 && mStop2, "R2 start/stop bits",
              int'({mStart, mStop1, mStop2}), 3);
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected character", int'(mByte), -1);
        end else begin
          mExp = expQ.pop_front();
          check(mByte == mExp, "R3 character value", int'(mByte), int'(mExp));
        end
      end
    end
  end

  // echo model
  logic [7:0] eSh;
  initial begin : echoDrv
    rxLine = 1'b1;
    forever begin
      @(negedge clk);
      if (echoPending) begin
        echoPending = 1'b0;
        eSh = echoByte;
        rxLine = 1'b0;
        repeat (BIT_CYC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          rxLine = eSh[i];
          repeat (BIT_CYC) @(negedge clk);
        end
        rxLine = 1'b1;
        echoStopCyc = cyc;
        repeat (2 * BIT_CYC) @(negedge clk);
      end
    end
  end

  // driver: pushes expected bytes and runs one command to its end
  int bResp, bDone, bErr, bStarts;
  task automatic runCmd(input logic [7:0] letter, input int mode, input bit withCr,
                        input bit intrude);
    bResp = respCnt; bDone = doneCnt; bErr = errCnt; bStarts = txStarts;
    expQ.push_back(letter);
    if (withCr) expQ.push_back(8'h0D);
    echoMode = mode;
    @(negedge clk);
    cmdLetter = letter; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b1, "R3 busy after strobe", int'(busy), 1);
    if (intrude) begin
      repeat (100) @(negedge clk);
      cmdLetter = "h"; cmdValid = 1'b1;
      @(negedge clk);
      cmdValid = 1'b0;
      check(busy == 1'b1, "R8 busy kept through strobe", int'(busy), 1);
    end
    while (busy) @(negedge clk);
    check((doneCnt - bDone) + (errCnt - bErr) == 1, "R11 one outcome per command",
          (doneCnt - bDone) + (errCnt - bErr), 1);
    repeat (300) @(negedge clk);
    check(expQ.size() == 0, "R3 all characters sent", expQ.size(), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin : stim
    repeat (5) @(negedge clk);
    check(txLine == 1'b1, "R1 txLine in reset", int'(txLine), 1);
    check({busy, respWindow, donePulse, errPulse} == 4'b0, "R1 flags in reset",
          int'({busy, respWindow, donePulse, errPulse}), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(txLine == 1'b1 && !busy, "R1 idle after reset", int'({txLine, busy}), 2);

    // timestamp request
    runCmd("o", 0, 1'b1, 1'b0);
    check(respCnt - bResp == RESP_CYC, "R5 window length o", respCnt - bResp, RESP_CYC);
    check(doneCnt - bDone == 1, "R5 done after window o", doneCnt - bDone, 1);
    check(txStarts - bStarts == 2, "R3 two characters o", txStarts - bStarts, 2);

    // quality request
    runCmd("g", 0, 1'b1, 1'b0);
    check(respCnt - bResp == RESP_CYC, "R5 window length g", respCnt - bResp, RESP_CYC);
    check(errCnt - bErr == 0, "R11 no error g", errCnt - bErr, 0);

    // resync: no window
    runCmd("h", 0, 1'b1, 1'b0);
    check(respCnt - bResp == 0, "R6 no window for resync", respCnt - bResp, 0);
    check(doneCnt - bDone == 1, "R6 done for resync", doneCnt - bDone, 1);

    // upper-case letter, same low nibble as quality request
    runCmd(8'h47, 0, 1'b1, 1'b0);
    check(respCnt - bResp == RESP_CYC, "R3 low nibble selects command",
          respCnt - bResp, RESP_CYC);

    // unsupported letter
    bStarts = txStarts;
    @(negedge clk);
    cmdLetter = "a"; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b0, "R7 unsupported letter not accepted", int'(busy), 0);
    repeat (400) @(negedge clk);
    check(txStarts == bStarts && !busy, "R7 nothing sent", txStarts - bStarts, 0);

    // strobe while busy
    runCmd("o", 0, 1'b1, 1'b1);
    check(txStarts - bStarts == 2, "R8 no extra characters", txStarts - bStarts, 2);
    check(respCnt - bResp == RESP_CYC, "R8 command unaffected", respCnt - bResp, RESP_CYC);

    // wrong echo
    runCmd("o", 1, 1'b0, 1'b0);
    check(errCnt - bErr == 1, "R9 error on wrong echo", errCnt - bErr, 1);
    check(txStarts - bStarts == 1, "R9 carriage return withheld", txStarts - bStarts, 1);
    check(doneCnt - bDone == 0, "R11 no done on error", doneCnt - bDone, 0);

    // missing echo
    runCmd("g", 2, 1'b0, 1'b0);
    check(errCnt - bErr == 1, "R10 error on missing echo", errCnt - bErr, 1);
    check(errCyc - lastStart >= ECHO_CYC && errCyc - lastStart <= ECHO_CYC + 2,
          "R10 timeout instant", errCyc - lastStart, ECHO_CYC);
    check(txStarts - bStarts == 1, "R10 single character", txStarts - bStarts, 1);

    // recovery after errors
    runCmd("h", 0, 1'b1, 1'b0);
    check(doneCnt - bDone == 1, "R6 recovery after error", doneCnt - bDone, 1);

    finishRun();
  end

endmodule